// File: doc/BRIEF.md
# Flash Programming-Mode Controller with Security Register

This block lets an external programmer read, write, verify and bulk-erase a small on-chip code store. It decodes a set of control pins and two high-voltage indications into one mode at a time. Those modes are read, output disable, program, program verify, erase, erase verify and inhibit. It then drives a byte array through a 16-bit address port and an 8-bit data port. Programming only clears bits, because the new byte is ANDed into the stored byte. Only a full erase can set bits back to one.

Next to the array sits an eight-bit security register. The programmer reaches it at address FFFFh. Like the array, its bits can only fall until the next erase. Four of its bits matter at run time:
- one blocks all reads in programming mode;
- one stops table reads (MOVC) that run from external code from seeing internal code;
- one enables a fixed XOR encoding of the bus data leaving the chip;
- one selects half oscillator gain.

Write pulses are modelled in clock cycles. A program or erase takes effect only once the pin code has been held for a set number of consecutive cycles, and only once per pulse.

Top module: `flash_prog_ctrl`

## Requirements
- R1: With prog_mode=1, a9_ctl=0, ce_n=0, oe_n=0 and neither vcp_ok nor vep_ok, the block is in read mode. It sets pd_oe=1 and drives pd_out with the byte at pa: array bytes for pa below 2**ARR_AW, the security register at FFFFh, and FFh for any other address.
- R2: Whenever oe_n=1, pd_oe is 0 and pd_out is 00h.
- R3: Program mode is a9_ctl=0, ce_n=0, oe_n=1 and vcp_ok=1 (with vep_ok=0). Once this code has been held for PGM_CYC consecutive cycles, the byte at pa becomes old AND pd_in, exactly once per pulse. A shorter pulse changes nothing.
- R4: Program verify is a9_ctl=0, ce_n=1, oe_n=0 and vcp_ok=1 (with vep_ok=0). It drives the stored byte on pd_out in the same way as read.
- R5: Erase mode is a9_ctl=1, ce_n=0, oe_n=1 and vep_ok=1. Once this code has been held for ERS_CYC consecutive cycles, every array byte and every security bit becomes 1. A shorter pulse changes nothing. Erase verify (a9_ctl=1, ce_n=1, oe_n=0, vep_ok=1) reads back like R1.
- R6: Two cases leave the array, the security register and pd_oe unchanged or off. The first is ce_n=1 and oe_n=1 with either high-voltage flag set (inhibit). The second is any pin code not listed in R1 to R5, such as a9_ctl=1 with only vcp_ok.
- R7: A program at pa=FFFFh ANDs pd_in into the security register. A security bit at 0 never returns to 1 except through erase.
- R8: While security bit 0 is 0 (lock), every read, program verify and erase verify returns FFh, for both the array and the security register.
- R9: movc_int_sel=1 and movc_data=array byte only when all of these hold: movc_req=1, movc_addr is at most 3FFFh and inside the array, and either security bit 1 is 1 or run_int_exec=1. Otherwise movc_int_sel=0 and movc_data=FFh.
- R10: p0_pins equals p0_raw while security bit 2 is 1, and p0_raw XOR ENC_KEY (default 5Ah) while it is 0.
- R11: osc_half_gain is the inverse of security bit 7.
- R12: After reset the array and the security register hold all ones and pd_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_mode | input | 1 | Programming mode active |
| a9_ctl | input | 1 | Erase-group select pin |
| ce_n | input | 1 | Chip enable / write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| vcp_ok | input | 1 | Programming voltage present |
| vep_ok | input | 1 | Erase voltage present |
| pa | input | 16 | Programming address |
| pd_in | input | 8 | Programming write data |
| pd_out | output | 8 | Programming read data |
| pd_oe | output | 1 | Read data drive enable |
| run_int_exec | input | 1 | Executing instruction lies in internal code space |
| movc_req | input | 1 | Run-time table read request |
| movc_addr | input | 16 | Run-time table read address |
| movc_int_sel | output | 1 | Table read served from internal array |
| movc_data | output | 8 | Table read data |
| p0_raw | input | 8 | Bus data before encoding |
| p0_pins | output | 8 | Bus data as presented on the pins |
| osc_half_gain | output | 1 | Oscillator at half gain |

## Verification
A program pulse completes on a clock edge. A run-time table read of the same byte can be asked for in the very cycle that edge closes. The bench holds a table read on the address being programmed throughout the final pulse cycle. It requires the old byte before that edge and the ANDed byte right after it, so any early or late write shows up. It also runs pulses one cycle short of the threshold next to pulses that reach it exactly. This shows the commit is counted on the right edge and fires only once.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;

    typedef enum logic [2:0] {
        MODE_IDLE = 3'd0,
        MODE_READ = 3'd1,
        MODE_ODIS = 3'd2,
        MODE_PGM  = 3'd3,
        MODE_PVFY = 3'd4,
        MODE_ERS  = 3'd5,
        MODE_EVFY = 3'd6,
        MODE_INH  = 3'd7
    } fpm_mode_e;

    localparam logic [15:0] SEC_ADDR = 16'hFFFF;
    localparam logic [15:0] INT_TOP  = 16'h3FFF;

    localparam int SEC_LOCK = 0;
    localparam int SEC_MOVC = 1;
    localparam int SEC_ENC  = 2;
    localparam int SEC_GAIN = 7;

endpackage

// File: rtl/fpm_mode_decode.sv
module fpm_mode_decode
    import flash_prog_pkg::*;
(
    input  logic      prog_mode,
    input  logic      a9_ctl,
    input  logic      ce_n,
    input  logic      oe_n,
    input  logic      vcp_ok,
    input  logic      vep_ok,
    output fpm_mode_e mode
);

    always_comb begin
        mode = MODE_IDLE;
        if (prog_mode) begin
            if (ce_n && oe_n) begin
                mode = (vcp_ok || vep_ok) ? MODE_INH : MODE_ODIS;
            end else if (vep_ok) begin
                if (a9_ctl && !ce_n && oe_n)      mode = MODE_ERS;
                else if (a9_ctl && ce_n && !oe_n) mode = MODE_EVFY;
            end else if (vcp_ok) begin
                if (!a9_ctl && !ce_n && oe_n)      mode = MODE_PGM;
                else if (!a9_ctl && ce_n && !oe_n) mode = MODE_PVFY;
            end else if (!a9_ctl) begin
                if (!ce_n && !oe_n)     mode = MODE_READ;
                else if (!ce_n && oe_n) mode = MODE_ODIS;
            end
        end
    end

endmodule

// File: rtl/fpm_pulse_timer.sv
module fpm_pulse_timer
    import flash_prog_pkg::*;
#(
    parameter int PGM_CYC = 6,
    parameter int ERS_CYC = 10
) (
    input  logic      clk,
    input  logic      rst_n,
    input  fpm_mode_e mode,
    output logic      pgm_fire,
    output logic      ers_fire
);

    localparam int CMAX = (PGM_CYC > ERS_CYC) ? PGM_CYC : ERS_CYC;
    localparam int CW   = $clog2(CMAX + 1);
    localparam logic [CW-1:0] PGM_LAST = CW'(PGM_CYC - 1);
    localparam logic [CW-1:0] ERS_LAST = CW'(ERS_CYC - 1);

    typedef struct packed {
        fpm_mode_e     prev;
        logic [CW-1:0] run;
    } tmr_t;

    tmr_t          st_d, st_q;
    logic [CW-1:0] run_now;

    always_comb begin
        // cycles already spent in the present mode before this one
        run_now  = (mode == st_q.prev) ? st_q.run : '0;
        pgm_fire = (mode == MODE_PGM) && (run_now == PGM_LAST);
        ers_fire = (mode == MODE_ERS) && (run_now == ERS_LAST);
        st_d.prev = mode;
        st_d.run  = (run_now == '1) ? run_now : run_now + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prev <= MODE_IDLE;
            st_q.run  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/fpm_store.sv
module fpm_store
    import flash_prog_pkg::*;
#(
    parameter int ARR_AW = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pgm_fire,
    input  logic        ers_fire,
    input  logic [15:0] wr_addr,
    input  logic [7:0]  wr_data,
    input  logic [15:0] rd_a_addr,
    output logic [7:0]  rd_a_data,
    output logic        rd_a_hit,
    input  logic [15:0] rd_b_addr,
    output logic [7:0]  rd_b_data,
    output logic        rd_b_hit,
    output logic [7:0]  sec_q
);

    // ARR_AW must stay at or below 14 so the array fits the internal code space
    localparam int DEPTH = 2 ** ARR_AW;
    localparam logic [15:0] LIMIT = 16'(DEPTH);

    logic [7:0] mem_q [DEPTH];
    logic [7:0] mem_d [DEPTH];
    logic [7:0] sec_d;
    logic       wr_hit;

    assign wr_hit    = wr_addr < LIMIT;
    assign rd_a_hit  = rd_a_addr < LIMIT;
    assign rd_b_hit  = rd_b_addr < LIMIT;
    assign rd_a_data = mem_q[rd_a_addr[ARR_AW-1:0]];
    assign rd_b_data = mem_q[rd_b_addr[ARR_AW-1:0]];

    always_comb begin
        mem_d = mem_q;
        sec_d = sec_q;
        if (ers_fire) begin
            for (int i = 0; i < DEPTH; i++) mem_d[i] = 8'hFF;
            sec_d = 8'hFF;
        end else if (pgm_fire) begin
            if (wr_addr == SEC_ADDR) begin
                sec_d = sec_q & wr_data;
            end else if (wr_hit) begin
                mem_d[wr_addr[ARR_AW-1:0]] = mem_q[wr_addr[ARR_AW-1:0]] & wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
            sec_q <= 8'hFF;
        end else begin
            mem_q <= mem_d;
            sec_q <= sec_d;
        end
    end

endmodule

// File: rtl/fpm_code_guard.sv
module fpm_code_guard
    import flash_prog_pkg::*;
#(
    parameter logic [7:0] ENC_KEY = 8'h5A
) (
    input  logic [7:0]  sec,
    input  logic        run_int_exec,
    input  logic        movc_req,
    input  logic [15:0] movc_addr,
    input  logic        arr_hit,
    input  logic [7:0]  arr_byte,
    input  logic [7:0]  p0_raw,
    output logic        movc_int_sel,
    output logic [7:0]  movc_data,
    output logic [7:0]  p0_pins,
    output logic        osc_half_gain
);

    logic tgt_int, allowed;

    always_comb begin
        tgt_int       = (movc_addr <= INT_TOP) && arr_hit;
        allowed       = sec[SEC_MOVC] || run_int_exec;
        movc_int_sel  = movc_req && tgt_int && allowed;
        movc_data     = movc_int_sel ? arr_byte : 8'hFF;
        p0_pins       = sec[SEC_ENC] ? p0_raw : (p0_raw ^ ENC_KEY);
        osc_half_gain = !sec[SEC_GAIN];
    end

endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
    import flash_prog_pkg::*;
#(
    parameter int         ARR_AW  = 8,
    parameter int         PGM_CYC = 6,
    parameter int         ERS_CYC = 10,
    parameter logic [7:0] ENC_KEY = 8'h5A
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        prog_mode,
    input  logic        a9_ctl,
    input  logic        ce_n,
    input  logic        oe_n,
    input  logic        vcp_ok,
    input  logic        vep_ok,
    input  logic [15:0] pa,
    input  logic [7:0]  pd_in,
    output logic [7:0]  pd_out,
    output logic        pd_oe,
    input  logic        run_int_exec,
    input  logic        movc_req,
    input  logic [15:0] movc_addr,
    output logic        movc_int_sel,
    output logic [7:0]  movc_data,
    input  logic [7:0]  p0_raw,
    output logic [7:0]  p0_pins,
    output logic        osc_half_gain
);

    fpm_mode_e  mode;
    logic       pgm_fire, ers_fire;
    logic [7:0] sec_q;
    logic [7:0] pa_byte, mv_byte;
    logic       pa_hit, mv_hit;
    logic       rd_mode, locked;

    fpm_mode_decode u_dec (
        .prog_mode (prog_mode),
        .a9_ctl    (a9_ctl),
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .vcp_ok    (vcp_ok),
        .vep_ok    (vep_ok),
        .mode      (mode)
    );

    fpm_pulse_timer #(
        .PGM_CYC (PGM_CYC),
        .ERS_CYC (ERS_CYC)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .pgm_fire (pgm_fire),
        .ers_fire (ers_fire)
    );

    fpm_store #(
        .ARR_AW (ARR_AW)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .pgm_fire  (pgm_fire),
        .ers_fire  (ers_fire),
        .wr_addr   (pa),
        .wr_data   (pd_in),
        .rd_a_addr (pa),
        .rd_a_data (pa_byte),
        .rd_a_hit  (pa_hit),
        .rd_b_addr (movc_addr),
        .rd_b_data (mv_byte),
        .rd_b_hit  (mv_hit),
        .sec_q     (sec_q)
    );

    fpm_code_guard #(
        .ENC_KEY (ENC_KEY)
    ) u_guard (
        .sec           (sec_q),
        .run_int_exec  (run_int_exec),
        .movc_req      (movc_req),
        .movc_addr     (movc_addr),
        .arr_hit       (mv_hit),
        .arr_byte      (mv_byte),
        .p0_raw        (p0_raw),
        .movc_int_sel  (movc_int_sel),
        .movc_data     (movc_data),
        .p0_pins       (p0_pins),
        .osc_half_gain (osc_half_gain)
    );

    always_comb begin
        rd_mode = (mode == MODE_READ) || (mode == MODE_PVFY) || (mode == MODE_EVFY);
        locked  = !sec_q[SEC_LOCK];
        pd_oe   = rd_mode;
        if (!rd_mode)               pd_out = 8'h00;
        else if (locked)            pd_out = 8'hFF;
        else if (pa == SEC_ADDR)    pd_out = sec_q;
        else if (pa_hit)            pd_out = pa_byte;
        else                        pd_out = 8'hFF;
    end

endmodule

// File: rtl/fpm_checker.sv
module fpm_checker
    import flash_prog_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        oe_n,
    input logic        pd_oe,
    input logic [7:0]  pd_out,
    input logic [7:0]  sec_q,
    input logic        pgm_fire,
    input logic        ers_fire,
    input fpm_mode_e   mode,
    input logic        movc_int_sel,
    input logic [15:0] movc_addr
);

    // R2
    oe_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (!pd_oe && pd_out == 8'h00));

    // R3
    pgm_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_fire |=> !pgm_fire);

    // R5
    ers_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ers_fire |=> (sec_q == 8'hFF));

    // R6
    inh_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_INH) |-> (!pgm_fire && !ers_fire && !pd_oe));

    // R7
    sec_fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ers_fire |=> ((sec_q & ~$past(sec_q)) == 8'h00));

    // R8
    lock_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_oe && !sec_q[SEC_LOCK]) |-> (pd_out == 8'hFF));

    // R9
    movc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        movc_int_sel |-> (movc_addr <= INT_TOP));

endmodule

bind flash_prog_ctrl fpm_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .oe_n         (oe_n),
    .pd_oe        (pd_oe),
    .pd_out       (pd_out),
    .sec_q        (sec_q),
    .pgm_fire     (pgm_fire),
    .ers_fire     (ers_fire),
    .mode         (mode),
    .movc_int_sel (movc_int_sel),
    .movc_addr    (movc_addr)
);

// File: tb/flash_prog_ctrl_test.sv
`timescale 1ns/1ps
module flash_prog_ctrl_test;

    localparam int         PGM_CYC = 6;
    localparam int         ERS_CYC = 10;
    localparam logic [7:0] KEY     = 8'h5A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prog_mode = 1'b0, a9_ctl = 1'b0, ce_n = 1'b1, oe_n = 1'b1;
    logic        vcp_ok = 1'b0, vep_ok = 1'b0;
    logic [15:0] pa = '0;
    logic [7:0]  pd_in = '0;
    logic [7:0]  pd_out;
    logic        pd_oe;
    logic        run_int_exec = 1'b0, movc_req = 1'b0;
    logic [15:0] movc_addr = '0;
    logic        movc_int_sel;
    logic [7:0]  movc_data;
    logic [7:0]  p0_raw = '0;
    logic [7:0]  p0_pins;
    logic        osc_half_gain;

    int checks = 0;
    int fails  = 0;
    logic [7:0] exp_mem [256];
    logic [7:0] exp_sec;

    always #4 clk = ~clk;

    flash_prog_ctrl #(.ARR_AW(8), .PGM_CYC(PGM_CYC), .ERS_CYC(ERS_CYC), .ENC_KEY(KEY)) uut (
        .clk(clk), .rst_n(rst_n), .prog_mode(prog_mode), .a9_ctl(a9_ctl), .ce_n(ce_n),
        .oe_n(oe_n), .vcp_ok(vcp_ok), .vep_ok(vep_ok), .pa(pa), .pd_in(pd_in),
        .pd_out(pd_out), .pd_oe(pd_oe), .run_int_exec(run_int_exec), .movc_req(movc_req),
        .movc_addr(movc_addr), .movc_int_sel(movc_int_sel), .movc_data(movc_data),
        .p0_raw(p0_raw), .p0_pins(p0_pins), .osc_half_gain(osc_half_gain)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [15:0] a);
        if (!exp_sec[0])        return 8'hFF;
        if (a == 16'hFFFF)      return exp_sec;
        if (a < 16'd256)        return exp_mem[a[7:0]];
        return 8'hFF;
    endfunction

    function automatic logic [8:0] exp_movc(input logic req, input logic intx, input logic [15:0] a);
        if (req && a < 16'd256 && (exp_sec[1] || intx)) return {1'b1, exp_mem[a[7:0]]};
        return {1'b0, 8'hFF};
    endfunction

    task automatic set_pins(input logic a9, cen, oen, vcp, vep);
        a9_ctl = a9; ce_n = cen; oe_n = oen; vcp_ok = vcp; vep_ok = vep;
    endtask

    task automatic hold_mode(input logic a9, cen, oen, vcp, vep,
                             input logic [15:0] a, input logic [7:0] d, input int cyc);
        @(negedge clk);
        pa = a; pd_in = d;
        set_pins(a9, cen, oen, vcp, vep);
        repeat (cyc) @(negedge clk);
        set_pins(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic program_byte(input logic [15:0] a, input logic [7:0] d, input int cyc);
        hold_mode(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, a, d, cyc);
        if (cyc >= PGM_CYC) begin
            if (a == 16'hFFFF) exp_sec = exp_sec & d;
            else if (a < 16'd256) exp_mem[a[7:0]] = exp_mem[a[7:0]] & d;
        end
    endtask

    task automatic read_chk(input string req, input logic [15:0] a,
                            input logic a9, cen, vcp, vep);
        @(negedge clk);
        pa = a;
        set_pins(a9, cen, 1'b0, vcp, vep);
        #1;
        chk(req, {15'd0, pd_oe}, 16'd1);
        chk(req, {8'd0, pd_out}, {8'd0, exp_read(a)});
    endtask

    task automatic movc_chk(input string req, input logic intx, input logic [15:0] a);
        logic [8:0] e;
        @(negedge clk);
        movc_req = 1'b1; run_int_exec = intx; movc_addr = a;
        #1;
        e = exp_movc(1'b1, intx, a);
        chk(req, {15'd0, movc_int_sel}, {15'd0, e[8]});
        chk(req, {8'd0, movc_data}, {8'd0, e[7:0]});
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog expired at %0t", $time);
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] seed_sink;
        seed_sink = 8'($urandom(32'd4242));
        for (int i = 0; i < 256; i++) exp_mem[i] = 8'hFF;
        exp_sec = 8'hFF;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R12 reset state
        chk("R12", {15'd0, pd_oe}, 16'd0);
        chk("R11", {15'd0, osc_half_gain}, 16'd0);
        p0_raw = 8'h3C; #1;
        chk("R10", {8'd0, p0_pins}, 16'h003C);
        prog_mode = 1'b1;
        read_chk("R12", 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0);
        read_chk("R12", 16'h00FF, 1'b0, 1'b0, 1'b0, 1'b0);
        read_chk("R12", 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0);
        read_chk("R1", 16'h1234, 1'b0, 1'b0, 1'b0, 1'b0);

        // R2 output disable
        @(negedge clk);
        set_pins(1'b0, 1'b0, 1'b1, 1'b0, 1'b0); #1;
        chk("R2", {7'd0, pd_oe, pd_out}, 16'h0000);
        set_pins(1'b0, 1'b1, 1'b1, 1'b0, 1'b0); #1;
        chk("R2", {7'd0, pd_oe, pd_out}, 16'h0000);

        // R3 program with run-time read on the same byte during the final cycle
        @(negedge clk);
        pa = 16'h0005; pd_in = 8'hA5;
        movc_req = 1'b1; run_int_exec = 1'b1; movc_addr = 16'h0005;
        set_pins(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        repeat (PGM_CYC - 1) @(negedge clk);
        #1;
        chk("R3", {8'd0, movc_data}, 16'h00FF);
        @(negedge clk);
        #1;
        chk("R3", {8'd0, movc_data}, 16'h00A5);
        set_pins(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        exp_mem[5] = 8'hA5;
        read_chk("R3", 16'h0005, 1'b0, 1'b0, 1'b0, 1'b0);
        program_byte(16'h0005, 8'h0F, PGM_CYC);
        read_chk("R3", 16'h0005, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R3", {8'd0, exp_mem[5]}, 16'h0005);
        program_byte(16'h0005, 8'h00, PGM_CYC - 1);
        read_chk("R3", 16'h0005, 1'b0, 1'b0, 1'b0, 1'b0);
        program_byte(16'h0006, 8'h3C, 3 * PGM_CYC);
        read_chk("R3", 16'h0006, 1'b0, 1'b0, 1'b0, 1'b0);

        // R4 program verify
        read_chk("R4", 16'h0005, 1'b0, 1'b1, 1'b1, 1'b0);
        read_chk("R4", 16'h0006, 1'b0, 1'b1, 1'b1, 1'b0);

        // R6 inhibit and unlisted codes
        @(negedge clk);
        pa = 16'h0005; pd_in = 8'h00;
        set_pins(1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
        repeat (2 * PGM_CYC) @(negedge clk);
        #1;
        chk("R6", {7'd0, pd_oe, pd_out}, 16'h0000);
        hold_mode(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0005, 8'h00, 2 * ERS_CYC);
        hold_mode(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 16'h0005, 8'h00, 2 * ERS_CYC);
        read_chk("R6", 16'h0005, 1'b0, 1'b0, 1'b0, 1'b0);

        // R3 random programs and readbacks
        for (int n = 0; n < 40; n++) begin
            logic [15:0] a;
            logic [7:0]  d;
            int          c;
            a = ($urandom_range(0, 9) == 0) ? 16'h0300 : 16'($urandom_range(0, 255));
            d = 8'($urandom);
            c = PGM_CYC - 2 + $urandom_range(0, 3);
            program_byte(a, d, c);
            read_chk("R3", a, 1'b0, 1'b0, 1'b0, 1'b0);
        end

        // R9 without restriction
        movc_chk("R9", 1'b0, 16'h0005);
        movc_chk("R9", 1'b0, 16'h4000);
        movc_chk("R9", 1'b1, 16'h0300);
        @(negedge clk); movc_req = 1'b0; #1;
        chk("R9", {7'd0, movc_int_sel, movc_data}, 16'h00FF);

        // R7 security register program
        program_byte(16'hFFFF, 8'hF9, PGM_CYC);
        read_chk("R7", 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0);
        program_byte(16'hFFFF, 8'hFF, PGM_CYC);
        read_chk("R7", 16'hFFFF, 1'b0, 1'b1, 1'b1, 1'b0);
        chk("R7", {8'd0, exp_sec}, 16'h00F9);

        // R9 with restriction, R10 encoding
        movc_chk("R9", 1'b0, 16'h0005);
        movc_chk("R9", 1'b1, 16'h0005);
        movc_chk("R9", 1'b1, 16'h0006);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            p0_raw = 8'($urandom); #1;
            chk("R10", {8'd0, p0_pins}, {8'd0, p0_raw ^ KEY});
        end

        // R11 gain
        program_byte(16'hFFFF, 8'h7F, PGM_CYC);
        @(negedge clk); #1;
        chk("R11", {15'd0, osc_half_gain}, 16'd1);

        // R8 lock
        program_byte(16'hFFFF, 8'hFE, PGM_CYC);
        read_chk("R8", 16'h0005, 1'b0, 1'b0, 1'b0, 1'b0);
        read_chk("R8", 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0);
        read_chk("R8", 16'h0006, 1'b0, 1'b1, 1'b1, 1'b0);
        read_chk("R8", 16'h0006, 1'b1, 1'b1, 1'b0, 1'b1);
        chk("R8", {8'd0, exp_read(16'h0005)}, 16'h00FF);

        // R5 erase: short pulse first
        hold_mode(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0000, 8'h00, ERS_CYC - 1);
        @(negedge clk); #1;
        chk("R5", {15'd0, osc_half_gain}, 16'd1);
        hold_mode(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0000, 8'h00, ERS_CYC);
        for (int i = 0; i < 256; i++) exp_mem[i] = 8'hFF;
        exp_sec = 8'hFF;
        @(negedge clk); #1;
        chk("R5", {15'd0, osc_half_gain}, 16'd0);
        chk("R5", {8'd0, p0_pins}, {8'd0, p0_raw});
        read_chk("R5", 16'h0005, 1'b1, 1'b1, 1'b0, 1'b1);
        read_chk("R5", 16'hFFFF, 1'b1, 1'b1, 1'b0, 1'b1);
        read_chk("R1", 16'h0006, 1'b0, 1'b0, 1'b0, 1'b0);

        @(negedge clk);
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

endmodule